// File: doc/BRIEF.md
# NOR Flash Command Sequencer

This block is a synthesizable behavioural model of the command side of a word-wide NOR flash. A host drives a simple synchronous bus: a write cycle carries an address and a data word, and a read cycle returns one word on the next clock. Writes are decoded as keyed command sequences: word program, sector erase, identifier mode, exit, suspend and resume. The storage behind it is a small array built from flip-flops, split into equal sectors.

A program or erase runs as a timed embedded operation. While it runs, reads return a status word instead of array data, and only the suspend command is honoured. The operation's result is written into the array on its last cycle, and the block then falls back to array read mode by itself. An erase can be suspended so that the array can be read. Identifier mode can be entered while an erase is suspended, and it can be left again. A resume command continues the suspended erase for the cycles it still had left.

Top module: `flash_cmd_top`

## Requirements
- R1: After the synchronous active-low reset, the block is in array read mode with `busy` low and `rdata` all zeros.
- R2: The writes (UNLOCK_A1, 0xAA), (UNLOCK_A2, 0x55), (UNLOCK_A1, 0xA0), then (A, D) program word A. On completion the word holds its old value ANDed with D, so a program never sets a bit. Any address may be programmed in any order. Read data appears in `rdata` one clock after the cycle with `rd_en` high. Command codes are compared on `wdata[7:0]`.
- R3: A write that does not match the next expected key step sends the decoder back to its idle step, and the sequence under way has no effect.
- R4: `busy` rises on the clock that accepts the final write of a program or erase. It stays high for exactly PROG_CYCLES (program) or ERASE_CYCLES (erase) clocks, and the block then returns to array read mode without any command.
- R5: A read while `busy` is high returns a status word. Bit 7 is 1, bit 6 inverts on every status read, bit 2 is 1 for an erase and 0 for a program, and every other bit is 0.
- R6: While `busy` is high, every write other than the suspend code 0xB0 (at any address) is ignored, including key sequences, identifier entry and the exit code.
- R7: Suspend (0xB0) during an operation drops `busy` and freezes the remaining cycle count, and reads then return array data. Resume (0x30 at any address) in suspended read mode raises `busy` again for the remaining cycles. Resume while nothing is suspended is ignored.
- R8: The writes (UNLOCK_A1, 0xAA), (UNLOCK_A2, 0x55), (UNLOCK_A1, 0x80), then (A, 0x30) erase the sector that holds A. On completion every word of that sector reads all ones, and no other sector changes.
- R9: The writes (UNLOCK_A1, 0xAA), (UNLOCK_A2, 0x55), (UNLOCK_A1, 0x90) enter identifier mode, from normal or suspended read. Reads then use address bits [1:0]: 0 returns MFR_ID, 1 returns DEV_ID, 2 returns the PROT_MAP bit of the sector in the top address bits in bit 0, and 3 returns 0. Bits above 7 are 0.
- R10: The exit code 0xF0 in identifier mode returns to array read. If an erase was suspended, it returns to suspended read, where resume is honoured.
- R11: A hardware reset during an operation aborts it. `busy` is low after reset, and the target word keeps its value from before the operation.
- R12: If a suspend write falls on the clock where the operation completes, completion wins: the result is stored and `busy` stays low. A read on that clock returns the status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write cycle strobe |
| rd_en | input | 1 | Read cycle strobe |
| addr | input | AW | Word address for reads and writes |
| wdata | input | DW | Write data or command code |
| rdata | output | DW | Read data, valid one clock after `rd_en` |
| busy | output | 1 | Embedded operation running (not suspended) |

## Verification
The critical overlap is between the timer expiring and a write or read arriving on that same clock. The bench places a suspend write, and separately a read, exactly on the completion edge. It counts the edges from the accepting write so that the collision is exact. It then judges the result by the stored word, the state of `busy`, and whether the colliding read returned the status word. A second overlap, a hardware reset in the middle of a program, is judged by reading the target word back afterwards.

// File: rtl/flash_cmd_pkg.sv
// Shared types for the flash command sequencer.
// Assumes data words are at least 8 bits wide, since the status bits sit in the low byte.
package flash_cmd_pkg;
    typedef enum logic [1:0] {
        MODE_ARRAY,
        MODE_IDENT,
        MODE_BUSY
    } mode_t;

    typedef enum logic [2:0] {
        STEP_IDLE,
        STEP_KEY1,
        STEP_KEY2,
        STEP_PROG,
        STEP_ERASE
    } step_t;

    localparam int STAT_BUSY_BIT   = 7;
    localparam int STAT_TOGGLE_BIT = 6;
    localparam int STAT_ERASE_BIT  = 2;
endpackage

// File: rtl/flash_word_array.sv
// Word storage built from flip-flops, split into 2**SW equal sectors.
// A program ANDs new data into one word. An erase sets a whole sector to ones.
// Assumes program and erase are never requested in the same cycle. Contents have no reset.
module flash_word_array #(
    parameter int AW = 6,
    parameter int DW = 16,
    parameter int SW = 2
) (
    input  logic          clk,
    input  logic          prog_en,
    input  logic [AW-1:0] prog_addr,
    input  logic [DW-1:0] prog_data,
    input  logic          erase_en,
    input  logic [SW-1:0] erase_sect,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_word
);
    localparam int DEPTH = 1 << AW;
    localparam int OFF_W = AW - SW;

    logic [DEPTH*DW-1:0] flat_q;

    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        localparam logic [AW-1:0] GA = AW'(g);
        logic [DW-1:0] word_q;
        // Update one word: a sector erase sets it, a program clears bits.
        always_ff @(posedge clk) begin
            if (erase_en && (GA[AW-1:OFF_W] == erase_sect))
                word_q <= '1;
            else if (prog_en && (prog_addr == GA))
                word_q <= word_q & prog_data;
        end
        assign flat_q[g*DW +: DW] = word_q;
    end

    assign rd_word = flat_q[rd_addr*DW +: DW];
endmodule

// File: rtl/flash_op_timer.sv
// Countdown for embedded operations. load sets the length; it counts while run is high.
// done pulses in the last counted cycle. The count holds while run is low (suspend).
module flash_op_timer #(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          run,
    output logic          done
);
    logic [CW-1:0] cnt_q;

    // Load, count down, or hold the remaining cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (run && (cnt_q > CW'(1)))
            cnt_q <= cnt_q - CW'(1);
    end

    assign done = run && (cnt_q == CW'(1));
endmodule

// File: rtl/flash_cmd_seq.sv
// Command decoder and mode state machine. Tracks key steps, the read mode,
// the suspend flag and the pending operation. Commits the result on timer done.
// Assumes command codes are compared on the low byte of the write data.
module flash_cmd_seq
    import flash_cmd_pkg::*;
#(
    parameter int            AW           = 6,
    parameter int            DW           = 16,
    parameter int            SW           = 2,
    parameter int            CW           = 6,
    parameter logic [AW-1:0] UNLOCK_A1    = 6'h15,
    parameter logic [AW-1:0] UNLOCK_A2    = 6'h2A,
    parameter logic [7:0]    KEY1         = 8'hAA,
    parameter logic [7:0]    KEY2         = 8'h55,
    parameter logic [7:0]    CMD_PROG     = 8'hA0,
    parameter logic [7:0]    CMD_IDENT    = 8'h90,
    parameter logic [7:0]    CMD_ERASE    = 8'h80,
    parameter logic [7:0]    CMD_ERASE_GO = 8'h30,
    parameter logic [7:0]    CMD_SUSP     = 8'hB0,
    parameter logic [7:0]    CMD_RESUME   = 8'h30,
    parameter logic [7:0]    CMD_EXIT     = 8'hF0,
    parameter int            PROG_CYCLES  = 20,
    parameter int            ERASE_CYCLES = 40
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          tmr_done,
    output mode_t         mode,
    output logic          susp,
    output logic          op_erase,
    output logic          tmr_load,
    output logic [CW-1:0] tmr_val,
    output logic          prog_en,
    output logic [AW-1:0] prog_addr,
    output logic [DW-1:0] prog_data,
    output logic          erase_en,
    output logic [SW-1:0] erase_sect
);
    mode_t         mode_q, mode_d;
    step_t         step_q, step_d;
    logic          susp_q, susp_d;
    logic          erase_q, erase_d;
    logic [AW-1:0] paddr_q, paddr_d;
    logic [DW-1:0] pdata_q, pdata_d;
    logic [7:0]    cmd;

    assign cmd = wdata[7:0];

    // Next-state decode of modes, key steps and the pending operation.
    always_comb begin
        mode_d   = mode_q;
        step_d   = step_q;
        susp_d   = susp_q;
        erase_d  = erase_q;
        paddr_d  = paddr_q;
        pdata_d  = pdata_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (mode_q)
            MODE_BUSY: begin
                if (tmr_done) begin
                    mode_d = MODE_ARRAY;
                    step_d = STEP_IDLE;
                    susp_d = 1'b0;
                end else if (wr_en && (cmd == CMD_SUSP)) begin
                    mode_d = MODE_ARRAY;
                    step_d = STEP_IDLE;
                    susp_d = 1'b1;
                end
            end
            MODE_IDENT: begin
                if (wr_en && (cmd == CMD_EXIT)) begin
                    mode_d = MODE_ARRAY;
                    step_d = STEP_IDLE;
                end
            end
            default: begin
                if (wr_en) begin
                    step_d = STEP_IDLE;
                    unique case (step_q)
                        STEP_IDLE: begin
                            if (susp_q && (cmd == CMD_RESUME)) begin
                                mode_d = MODE_BUSY;
                                susp_d = 1'b0;
                            end else if ((addr == UNLOCK_A1) && (cmd == KEY1)) begin
                                step_d = STEP_KEY1;
                            end
                        end
                        STEP_KEY1: begin
                            if ((addr == UNLOCK_A2) && (cmd == KEY2))
                                step_d = STEP_KEY2;
                        end
                        STEP_KEY2: begin
                            if (addr == UNLOCK_A1) begin
                                if (cmd == CMD_IDENT)
                                    mode_d = MODE_IDENT;
                                else if ((cmd == CMD_PROG) && !susp_q)
                                    step_d = STEP_PROG;
                                else if ((cmd == CMD_ERASE) && !susp_q)
                                    step_d = STEP_ERASE;
                            end
                        end
                        STEP_PROG: begin
                            mode_d   = MODE_BUSY;
                            erase_d  = 1'b0;
                            paddr_d  = addr;
                            pdata_d  = wdata;
                            tmr_load = 1'b1;
                            tmr_val  = CW'(PROG_CYCLES);
                        end
                        STEP_ERASE: begin
                            if (cmd == CMD_ERASE_GO) begin
                                mode_d   = MODE_BUSY;
                                erase_d  = 1'b1;
                                paddr_d  = addr;
                                tmr_load = 1'b1;
                                tmr_val  = CW'(ERASE_CYCLES);
                            end
                        end
                        default: step_d = STEP_IDLE;
                    endcase
                end
            end
        endcase
    end

    // State registers; a reset abandons any operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= MODE_ARRAY;
            step_q  <= STEP_IDLE;
            susp_q  <= 1'b0;
            erase_q <= 1'b0;
            paddr_q <= '0;
            pdata_q <= '0;
        end else begin
            mode_q  <= mode_d;
            step_q  <= step_d;
            susp_q  <= susp_d;
            erase_q <= erase_d;
            paddr_q <= paddr_d;
            pdata_q <= pdata_d;
        end
    end

    assign mode       = mode_q;
    assign susp       = susp_q;
    assign op_erase   = erase_q;
    assign prog_en    = (mode_q == MODE_BUSY) && tmr_done && !erase_q;
    assign erase_en   = (mode_q == MODE_BUSY) && tmr_done && erase_q;
    assign prog_addr  = paddr_q;
    assign prog_data  = pdata_q;
    assign erase_sect = paddr_q[AW-1 -: SW];
endmodule

// File: rtl/flash_cmd_top.sv
// Top of the flash command model. Connects the decoder, the timer and the array.
// Registers read data: array word, identifier code or status word, chosen by mode.
// Assumes DW >= 8 and 1 <= SW < AW.
module flash_cmd_top
    import flash_cmd_pkg::*;
#(
    parameter int            AW           = 6,
    parameter int            DW           = 16,
    parameter int            SW           = 2,
    parameter logic [AW-1:0] UNLOCK_A1    = 6'h15,
    parameter logic [AW-1:0] UNLOCK_A2    = 6'h2A,
    parameter logic [7:0]    CMD_SUSP     = 8'hB0,
    parameter logic [7:0]    MFR_ID       = 8'h3C,
    parameter logic [7:0]    DEV_ID       = 8'hA7,
    parameter logic [(1<<SW)-1:0] PROT_MAP = 4'b0100,
    parameter int            PROG_CYCLES  = 20,
    parameter int            ERASE_CYCLES = 40
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          busy
);
    localparam int MAXC = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
    localparam int CW   = $clog2(MAXC + 1);

    mode_t         mode_w;
    logic          susp_w, op_erase_w, tmr_load, tmr_done;
    logic [CW-1:0] tmr_val;
    logic          prog_en, erase_en;
    logic [AW-1:0] prog_addr;
    logic [DW-1:0] prog_data, arr_word, status_w, ident_w;
    logic [SW-1:0] erase_sect;
    logic          toggle_q;

    flash_cmd_seq #(
        .AW(AW), .DW(DW), .SW(SW), .CW(CW),
        .UNLOCK_A1(UNLOCK_A1), .UNLOCK_A2(UNLOCK_A2), .CMD_SUSP(CMD_SUSP),
        .PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .tmr_done(tmr_done), .mode(mode_w), .susp(susp_w), .op_erase(op_erase_w),
        .tmr_load(tmr_load), .tmr_val(tmr_val), .prog_en(prog_en),
        .prog_addr(prog_addr), .prog_data(prog_data), .erase_en(erase_en),
        .erase_sect(erase_sect)
    );

    flash_op_timer #(.CW(CW)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
        .run(mode_w == MODE_BUSY), .done(tmr_done)
    );

    flash_word_array #(.AW(AW), .DW(DW), .SW(SW)) u_arr (
        .clk(clk), .prog_en(prog_en), .prog_addr(prog_addr), .prog_data(prog_data),
        .erase_en(erase_en), .erase_sect(erase_sect), .rd_addr(addr), .rd_word(arr_word)
    );

    // Build the status word shown while an operation runs.
    always_comb begin
        status_w                  = '0;
        status_w[STAT_BUSY_BIT]   = 1'b1;
        status_w[STAT_TOGGLE_BIT] = toggle_q;
        status_w[STAT_ERASE_BIT]  = op_erase_w;
    end

    // Pick the identifier code selected by the low address bits.
    always_comb begin
        unique case (addr[1:0])
            2'd0:    ident_w = DW'(MFR_ID);
            2'd1:    ident_w = DW'(DEV_ID);
            2'd2:    ident_w = DW'(PROT_MAP[addr[AW-1 -: SW]]);
            default: ident_w = '0;
        endcase
    end

    // Register the read result; each status read inverts the toggle bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata    <= '0;
            toggle_q <= 1'b0;
        end else if (rd_en) begin
            unique case (mode_w)
                MODE_BUSY: begin
                    rdata    <= status_w;
                    toggle_q <= ~toggle_q;
                end
                MODE_IDENT: rdata <= ident_w;
                default:    rdata <= arr_word;
            endcase
        end
    end

    assign busy = (mode_w == MODE_BUSY);
endmodule

// File: rtl/flash_cmd_chk.sv
// Timing properties of the flash command model, bound to its top.
module flash_cmd_chk #(
    parameter int         DW       = 16,
    parameter logic [7:0] CMD_SUSP = 8'hB0
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic          rd_en,
    input logic [DW-1:0] wdata,
    input logic [DW-1:0] rdata,
    input logic          busy,
    input logic          tmr_done,
    input logic          suspended
);
    // R1
    idle_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> !busy);

    // R4
    auto_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && tmr_done) |=> (!busy && !suspended));

    // R6
    cmd_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tmr_done && !(wr_en && (wdata[7:0] == CMD_SUSP))) |=> busy);

    // R7
    suspend_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tmr_done && wr_en && (wdata[7:0] == CMD_SUSP)) |=> (!busy && suspended));

    // R5
    status_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rd_en) |=> rdata[7]);
endmodule

bind flash_cmd_top flash_cmd_chk #(.DW(DW), .CMD_SUSP(CMD_SUSP)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata),
    .rdata(rdata), .busy(busy), .tmr_done(tmr_done), .suspended(susp_w)
);

// File: tb/tb_flash_cmd_top.sv
`timescale 1ns/1ps
module tb_flash_cmd_top;
    localparam int AW = 6;
    localparam int DW = 16;
    localparam logic [AW-1:0] A1 = 6'h15;
    localparam logic [AW-1:0] A2 = 6'h2A;
    localparam int PROG_CYC  = 20;
    localparam int ERASE_CYC = 40;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          busy;

    int n_chk = 0;
    int n_bad = 0;
    logic [DW-1:0] model [64];

    flash_cmd_top dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .busy(busy)
    );

    always #2.5 clk = ~clk;

    task automatic report();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic keys();
        wr(A1, 16'h00AA);
        wr(A2, 16'h0055);
    endtask

    task automatic program_word(input logic [AW-1:0] a, input logic [DW-1:0] d);
        keys();
        wr(A1, 16'h00A0);
        wr(a, d);
    endtask

    task automatic erase_sector(input logic [AW-1:0] a);
        keys();
        wr(A1, 16'h0080);
        wr(a, 16'h0030);
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 200 && busy; i++) @(negedge clk);
    endtask

    function automatic logic [DW-1:0] exp_ident(input logic [AW-1:0] a);
        logic [3:0] prot = 4'b0100;
        case (a[1:0])
            2'd0:    return 16'h003C;
            2'd1:    return 16'h00A7;
            2'd2:    return {15'd0, prot[a[5:4]]};
            default: return 16'h0000;
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        report();
    end

    initial begin
        logic [DW-1:0] v, s1, s2;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", {15'd0, busy}, 16'h0000);
        chk("R1 rdata", rdata, 16'h0000);

        // R8 erase every sector
        for (int s = 0; s < 4; s++) begin
            erase_sector(AW'(s * 16 + 3));
            if (s == 0) chk("R8 busy", {15'd0, busy}, 16'h0001);
            wait_idle();
        end
        for (int i = 0; i < 64; i++) model[i] = 16'hFFFF;
        rd(6'h07, v); chk("R8 erased", v, 16'hFFFF);
        rd(6'h3E, v); chk("R8 erased", v, 16'hFFFF);

        // R4 exact duration, R2 store
        program_word(6'h05, 16'h1234);
        repeat (PROG_CYC - 1) @(negedge clk);
        chk("R4 still busy", {15'd0, busy}, 16'h0001);
        @(negedge clk);
        chk("R4 done", {15'd0, busy}, 16'h0000);
        model[5] = 16'h1234;
        rd(6'h05, v); chk("R2 program", v, model[5]);
        program_word(6'h05, 16'hFF0F); wait_idle();
        model[5] &= 16'hFF0F;
        rd(6'h05, v); chk("R2 and", v, model[5]);
        program_word(6'h05, 16'hFFFF); wait_idle();
        rd(6'h05, v); chk("R2 no set", v, model[5]);

        // R5 status word
        program_word(6'h09, 16'h00FF);
        rd(6'h09, s1); rd(6'h09, s2);
        chk("R5 busy bit", {15'd0, s1[7] & s2[7]}, 16'h0001);
        chk("R5 toggle", {15'd0, s1[6] ^ s2[6]}, 16'h0001);
        chk("R5 other bits", s1 & 16'hFF3F, 16'h0000);
        wait_idle(); model[9] &= 16'h00FF;

        // R6 commands ignored while busy
        program_word(6'h0C, 16'h0F0F);
        keys(); wr(A1, 16'h0090); wr(6'h00, 16'h00F0);
        program_word(6'h0D, 16'h0000);
        wait_idle(); model[12] &= 16'h0F0F;
        rd(6'h0C, v); chk("R6 op result", v, model[12]);
        rd(6'h0D, v); chk("R6 ignored prog", v, model[13]);

        // R3 broken sequences
        wr(A1, 16'h00AA); wr(6'h07, 16'h0000); wr(A2, 16'h0055); wr(A1, 16'h00A0);
        wr(6'h0E, 16'h0000);
        chk("R3 no busy", {15'd0, busy}, 16'h0000);
        rd(6'h0E, v); chk("R3 unchanged", v, model[14]);
        keys(); wr(A2, 16'h00A0); wr(6'h0F, 16'h0000);
        rd(6'h0F, v); chk("R3 wrong addr", v, model[15]);

        // R9 identifier mode, R10 exit
        keys(); wr(A1, 16'h0090);
        rd(6'h00, v); chk("R9 mfr", v, exp_ident(6'h00));
        rd(6'h01, v); chk("R9 dev", v, exp_ident(6'h01));
        rd(6'h22, v); chk("R9 prot", v, exp_ident(6'h22));
        rd(6'h02, v); chk("R9 unprot", v, exp_ident(6'h02));
        rd(6'h03, v); chk("R9 spare", v, exp_ident(6'h03));
        wr(6'h00, 16'h00F0);
        rd(6'h05, v); chk("R10 back to array", v, model[5]);

        // R7 suspend erase, R10 return to suspended read
        program_word(6'h31, 16'h0000); wait_idle(); model[49] = 16'h0000;
        erase_sector(6'h30);
        rd(6'h30, s1); chk("R5 erase flag", s1 & 16'h0084, 16'h0084);
        wr(6'h00, 16'h00B0);
        chk("R7 suspended", {15'd0, busy}, 16'h0000);
        rd(6'h31, v); chk("R7 array read", v, 16'h0000);
        repeat (60) @(negedge clk);
        chk("R7 frozen", {15'd0, busy}, 16'h0000);
        rd(6'h31, v); chk("R7 still old", v, 16'h0000);
        keys(); wr(A1, 16'h0090);
        rd(6'h01, v); chk("R9 from suspend", v, exp_ident(6'h01));
        wr(6'h00, 16'h00F0);
        rd(6'h31, v); chk("R10 suspended read", v, 16'h0000);
        wr(6'h00, 16'h0030);
        chk("R7 resumed", {15'd0, busy}, 16'h0001);
        wait_idle();
        for (int i = 48; i < 64; i++) model[i] = 16'hFFFF;
        rd(6'h31, v); chk("R7 erase done", v, model[49]);
        rd(6'h2F, v); chk("R8 other sector", v, model[47]);
        wr(6'h00, 16'h0030);
        chk("R7 resume ignored", {15'd0, busy}, 16'h0000);

        // R11 hardware reset aborts
        program_word(6'h14, 16'h0000);
        repeat (3) @(negedge clk);
        rst_n = 1'b0; repeat (2) @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk("R11 not busy", {15'd0, busy}, 16'h0000);
        rd(6'h14, v); chk("R11 word kept", v, model[20]);
        program_word(6'h14, 16'h00F0); wait_idle(); model[20] &= 16'h00F0;
        rd(6'h14, v); chk("R11 later program", v, model[20]);

        // R12 suspend on the completion edge
        program_word(6'h16, 16'h5A5A);
        repeat (PROG_CYC - 1) @(negedge clk);
        wr_en = 1'b1; addr = 6'h00; wdata = 16'h00B0;
        @(negedge clk); wr_en = 1'b0;
        chk("R12 not busy", {15'd0, busy}, 16'h0000);
        model[22] &= 16'h5A5A;
        rd(6'h16, v); chk("R12 stored", v, model[22]);
        program_word(6'h17, 16'h3C3C);
        repeat (PROG_CYC - 1) @(negedge clk);
        rd_en = 1'b1; addr = 6'h17;
        @(negedge clk); rd_en = 1'b0;
        chk("R12 read is status", rdata & 16'h0080, 16'h0080);
        model[23] &= 16'h3C3C;
        rd(6'h17, v); chk("R12 read after", v, model[23]);

        // R2 random programs at any address and order
        for (int k = 0; k < 30; k++) begin
            logic [AW-1:0] a;
            logic [DW-1:0] d;
            a = AW'($urandom % 64);
            d = DW'($urandom);
            if (d[7:0] == 8'hB0) d[7:0] = 8'hB1;
            program_word(a, d); wait_idle();
            model[a] &= d;
        end
        for (int k = 0; k < 30; k++) begin
            logic [AW-1:0] a;
            a = AW'($urandom % 64);
            rd(a, v); chk("R2 random", v, model[a]);
        end
        report();
    end
endmodule